// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-up

This block is a supervisory counter that is clocked by its own free-running clock (`wd_clk`), separate from the core clock. It keeps counting while the core is halted in sleep. Software restarts the count with a clear command. If the count ever runs out, the block raises one of two requests. When the core is awake it asks for a device reset. When the core is asleep it asks for a wake-up, and the core then carries on from where it stopped. Every expiry also drives an active-low time-out flag to 0. A power-on reset or a clear command sets the flag back to 1.

Two sources can switch the counter on. A fused configuration enable (`fuse_en`) forces it on, and software cannot stop it. When the fuse is 0, a software enable bit in an 8-bit control register decides. A 3-bit configuration field (`ps_sel`) sets a postscaler ratio. The postscaler stretches a base period of 2^BASE_W watchdog clocks by 2^ps_sel. Commands from the core domain cross into the watchdog domain through toggle handshakes. Expiry events return to the core domain as single-cycle pulses.

A three-state controller runs in the watchdog domain:
- **ST_IDLE**: the counter is disabled and held at zero.
- **ST_RUN**: the core is awake and the counter is counting.
- **ST_DOZE**: the core is asleep and the counter is counting.

Its transitions are:
- IDLE→RUN when the effective enable rises.
- RUN→IDLE and DOZE→IDLE when the enable drops.
- RUN→DOZE on a sleep command.
- RUN→RUN on an expiry, which sends a reset request.
- DOZE→RUN on an expiry, which sends a wake-up request.

Top module: `wdog_top`

## Requirements
- R1: The control register reads as {7'b0, swen}. Bits 7..1 always read 0. Bit 0 (swen) takes reg_wdata[0] on a write and is 0 after power-on.
- R2: With fuse_en = 1 the counter runs whatever value swen holds, and writing swen = 0 does not stop it.
- R3: With fuse_en = 0 and swen = 0 the counter never expires, so neither rst_req nor wake_req is raised.
- R4: With fuse_en = 0 and swen = 1 the counter runs and expires.
- R5: An expiry comes 2^(BASE_W+ps_sel) wd_clk cycles after the last clear. ps_sel value k gives a postscaler ratio of 2^k, for k from 0 to 7.
- R6: A clear command zeroes both the base counter and the postscaler. Clearing more often than the period prevents every expiry.
- R7: A sleep command restarts the count and marks the core as asleep. An expiry while asleep pulses wake_req and never rst_req.
- R8: An expiry while the core is awake pulses rst_req and not wake_req.
- R9: to_n is 1 after power-on. It becomes 0 after any expiry and returns to 1 after a clear command.
- R10: rst_req and wake_req are each exactly one core_clk cycle wide.
- R11: After a wake-up the core counts as awake again, so the next expiry with no clear in between gives rst_req one period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Active-low power-on reset, asynchronous |
| wd_clk | input | 1 | Independent watchdog clock |
| fuse_en | input | 1 | Fused enable; 1 forces the counter on |
| ps_sel | input | 3 | Postscaler ratio select, divide by 2^ps_sel |
| reg_wr | input | 1 | Control register write strobe (core domain) |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| clr_cmd | input | 1 | One-cycle clear command (core domain) |
| sleep_cmd | input | 1 | One-cycle sleep-entry command (core domain) |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_n | output | 1 | Active-low time-out status flag |

## Verification
The hardest situation to reach from the ports is an expiry that lands while the controller is in ST_DOZE. It needs a sleep command to cross the toggle handshake and restart the count, and then a whole postscaled period with no clear. The bench issues a sleep command in place of a clear. It then waits through a measured window and checks that only wake_req appears. Next it waits a second period with no stimulus at all, to show that the controller went back to ST_RUN and that the next expiry is a reset request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DOZE = 2'd2
    } wd_state_t;

    localparam int CTRL_W = 8;
    localparam int SEL_W  = 3;
endpackage

// File: rtl/wdog_bitsync.sv
module wdog_bitsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdog_xfer.sv
module wdog_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic            tog;
    logic [STAGES:0] sync;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) tog <= 1'b0;
        else            tog <= tog ^ src_pulse;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            sync      <= '0;
            dst_pulse <= 1'b0;
        end else begin
            sync      <= {sync[STAGES-1:0], tog};
            dst_pulse <= sync[STAGES-1] ^ sync[STAGES];
        end
    end
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
    parameter int BASE_W = 4,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int POST_W = (1 << SEL_W) - 1;
    localparam logic [POST_W-1:0] ALL_ONES = '1;

    logic [BASE_W-1:0] base_q;
    logic [POST_W-1:0] post_q;
    logic [POST_W-1:0] post_lim;
    logic              tick;

    assign post_lim = ALL_ONES >> (SEL_W'(POST_W) - sel);
    assign tick     = run && (base_q == '1);
    assign expire   = tick && (post_q == post_lim) && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            post_q <= '0;
        end else if (clr || !run) begin
            base_q <= '0;
            post_q <= '0;
        end else begin
            base_q <= base_q + 1'b1;
            if (tick) post_q <= (post_q == post_lim) ? '0 : post_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
    parameter int BASE_W = 4,
    parameter int SYNC_N = 2
) (
    input  logic                          core_clk,
    input  logic                          core_rst_n,
    input  logic                          wd_clk,
    input  logic                          fuse_en,
    input  logic [wdog_pkg::SEL_W-1:0]    ps_sel,
    input  logic                          reg_wr,
    input  logic [wdog_pkg::CTRL_W-1:0]   reg_wdata,
    output logic [wdog_pkg::CTRL_W-1:0]   reg_rdata,
    input  logic                          clr_cmd,
    input  logic                          sleep_cmd,
    output logic                          rst_req,
    output logic                          wake_req,
    output logic                          to_n
);
    import wdog_pkg::*;

    // ---------------- core domain: control register and flag
    logic swen_q;
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[CTRL_W-1:1];

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n)  swen_q <= 1'b0;
        else if (reg_wr)  swen_q <= reg_wdata[0];
    end

    assign reg_rdata = {{(CTRL_W-1){1'b0}}, swen_q};

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n)               to_n <= 1'b1;
        else if (rst_req || wake_req)  to_n <= 1'b0;
        else if (clr_cmd)              to_n <= 1'b1;
    end

    // ---------------- watchdog domain reset and enable
    logic wd_rst_n;
    logic en_s;

    wdog_bitsync #(.STAGES(SYNC_N)) u_rst_sync (
        .clk(wd_clk), .rst_n(core_rst_n), .d(1'b1), .q(wd_rst_n)
    );

    wdog_bitsync #(.STAGES(SYNC_N)) u_en_sync (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(fuse_en | swen_q), .q(en_s)
    );

    // ---------------- command crossings into the watchdog domain
    logic clr_p;
    logic sleep_p;

    wdog_xfer #(.STAGES(SYNC_N)) u_clr_x (
        .src_clk(core_clk), .src_rst_n(core_rst_n), .src_pulse(clr_cmd),
        .dst_clk(wd_clk), .dst_rst_n(wd_rst_n), .dst_pulse(clr_p)
    );

    wdog_xfer #(.STAGES(SYNC_N)) u_slp_x (
        .src_clk(core_clk), .src_rst_n(core_rst_n), .src_pulse(sleep_cmd),
        .dst_clk(wd_clk), .dst_rst_n(wd_rst_n), .dst_pulse(sleep_p)
    );

    // ---------------- controller
    wd_state_t state_q;
    wd_state_t state_d;
    logic      expire;
    logic      fire_rst;
    logic      fire_wake;

    wdog_divider #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_div (
        .clk(wd_clk), .rst_n(wd_rst_n),
        .run((state_q != ST_IDLE) && en_s),
        .clr(clr_p || sleep_p),
        .sel(ps_sel),
        .expire(expire)
    );

    always_ff @(posedge wd_clk or negedge wd_rst_n) begin
        if (!wd_rst_n) state_q <= ST_IDLE;
        else           state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_s) state_d = ST_RUN;
            ST_RUN: begin
                if (!en_s)        state_d = ST_IDLE;
                else if (sleep_p) state_d = ST_DOZE;
            end
            ST_DOZE: begin
                if (!en_s)        state_d = ST_IDLE;
                else if (expire)  state_d = ST_RUN;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fire_rst  = 1'b0;
        fire_wake = 1'b0;
        unique case (state_q)
            ST_RUN:  fire_rst  = en_s && !sleep_p && expire;
            ST_DOZE: fire_wake = en_s && expire;
            default: ;
        endcase
    end

    // ---------------- event crossings back to the core domain
    wdog_xfer #(.STAGES(SYNC_N)) u_rst_x (
        .src_clk(wd_clk), .src_rst_n(wd_rst_n), .src_pulse(fire_rst),
        .dst_clk(core_clk), .dst_rst_n(core_rst_n), .dst_pulse(rst_req)
    );

    wdog_xfer #(.STAGES(SYNC_N)) u_wake_x (
        .src_clk(wd_clk), .src_rst_n(wd_rst_n), .src_pulse(fire_wake),
        .dst_clk(core_clk), .dst_rst_n(core_rst_n), .dst_pulse(wake_req)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
    input logic                core_clk,
    input logic                core_rst_n,
    input logic                wd_clk,
    input logic                wd_rst_n,
    input logic                rst_req,
    input logic                wake_req,
    input logic                to_n,
    input logic [7:0]          reg_rdata,
    input logic                en_s,
    input wdog_pkg::wd_state_t state_q,
    input logic                expire
);
    import wdog_pkg::*;

    // R1
    rdata_pad_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        reg_rdata[7:1] == 7'd0);

    // R10
    req_width_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (rst_req || wake_req) |=> !(rst_req || wake_req));

    // R7
    req_excl_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        !(rst_req && wake_req));

    // R9
    flag_drop_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (rst_req || wake_req) |=> !to_n);

    // R3
    idle_follow_chk: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        !en_s |=> state_q == ST_IDLE);

    // R3
    idle_quiet_chk: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        state_q == ST_IDLE |-> !expire);

    // R11
    doze_wake_chk: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        (state_q == ST_DOZE && expire && en_s) |=> state_q == ST_RUN);
endmodule

bind wdog_top wdog_chk u_chk (
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
    .rst_req(rst_req), .wake_req(wake_req), .to_n(to_n),
    .reg_rdata(reg_rdata), .en_s(en_s), .state_q(state_q), .expire(expire)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
    localparam int BASE_W = 4;
    localparam int RATIO  = 3;   // core cycles per wd cycle

    logic       clk = 1'b0;
    logic       wclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fuse_en = 1'b0;
    logic [2:0] ps_sel = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       clr_cmd = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       rst_req, wake_req, to_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;    // 50 MHz
    always #30 wclk = ~wclk;  // watchdog clock

    wdog_top #(.BASE_W(BASE_W)) u0 (
        .core_clk(clk), .core_rst_n(rst_n), .wd_clk(wclk),
        .fuse_en(fuse_en), .ps_sel(ps_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clr_cmd(clr_cmd), .sleep_cmd(sleep_cmd),
        .rst_req(rst_req), .wake_req(wake_req), .to_n(to_n)
    );

    // vector: [6] fuse, [5] swen, [4:2] sel, [1] expect expiry, [0] use sleep
    localparam logic [6:0] VEC [8] = '{
        7'b1_0_000_1_0,
        7'b0_1_010_1_0,
        7'b0_0_011_0_0,
        7'b1_1_101_1_0,
        7'b0_1_001_1_1,
        7'b1_0_111_1_1,
        7'b0_1_111_1_0,
        7'b0_0_000_0_1
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(5);
        rst_n = 1'b1;
        cycles(10);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_cmd = 1'b1;
        @(negedge clk);
        clr_cmd = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
    endtask

    // kind: 0 none, 1 reset request, 2 wake request
    task automatic wait_evt(input int limit, output int cyc, output int kind);
        cyc = 0; kind = 0;
        while (cyc < limit && kind == 0) begin
            @(negedge clk);
            cyc++;
            if (rst_req)       kind = 1;
            else if (wake_req) kind = 2;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cyc, kind, p;
        do_reset();

        // reset state: R1, R9
        chk(reg_rdata == 8'h00, "R1 reset rdata", reg_rdata, 0);
        chk(to_n == 1'b1, "R9 reset flag", to_n, 1);
        chk(!rst_req && !wake_req, "R3 reset quiet", rst_req, 0);

        // R1 register padding
        wr(8'hFF);
        chk(reg_rdata == 8'h01, "R1 write ff", reg_rdata, 1);
        wr(8'hFE);
        chk(reg_rdata == 8'h00, "R1 write fe", reg_rdata, 0);

        // vector table
        foreach (VEC[i]) begin
            do_reset();
            fuse_en = VEC[i][6];
            ps_sel  = VEC[i][4:2];
            wr({7'd0, VEC[i][5]});
            cycles(20);
            p = (1 << (BASE_W + int'(VEC[i][4:2]))) * RATIO;
            if (VEC[i][0]) pulse_sleep(); else pulse_clr();
            wait_evt(p + 60, cyc, kind);
            if (!VEC[i][1]) begin
                chk(kind == 0, "R3 disabled no expiry", kind, 0);
            end else if (VEC[i][0]) begin
                chk(kind == 2, "R7 sleep expiry gives wake", kind, 2);
                chk(cyc >= p && cyc <= p + 30, "R5 sleep period", cyc, p);
                wait_evt(p + 30, cyc, kind);
                chk(kind == 1, "R11 awake after wake", kind, 1);
                chk(cyc >= p - 12 && cyc <= p + 12, "R11 second period", cyc, p);
            end else begin
                chk(kind == 1, VEC[i][6] ? "R2 fused run reset" : "R4 soft run reset", kind, 1);
                chk(cyc >= p && cyc <= p + 30, "R5 awake period", cyc, p);
                @(negedge clk);
                chk(!rst_req && !wake_req, "R10 single cycle", rst_req, 0);
            end
        end

        // R6: periodic clear prevents expiry (period 48 core cycles)
        do_reset();
        fuse_en = 1'b1; ps_sel = 3'd0;
        cycles(20);
        kind = 0;
        for (int k = 0; k < 20; k++) begin
            int c2, k2;
            pulse_clr();
            wait_evt(24, c2, k2);
            if (k2 != 0) kind = k2;
        end
        chk(kind == 0, "R6 clears hold off expiry", kind, 0);

        // R8 then stop clearing
        wait_evt(200, cyc, kind);
        chk(kind == 1, "R8 awake expiry is reset", kind, 1);
        chk(!wake_req, "R8 no wake", wake_req, 0);
        cycles(2);
        chk(to_n == 1'b0, "R9 flag low after expiry", to_n, 0);
        pulse_clr();
        chk(to_n == 1'b1, "R9 flag set by clear", to_n, 1);

        // R2: software cannot stop fused watchdog
        wr(8'h00);
        chk(reg_rdata == 8'h00, "R2 swen readback", reg_rdata, 0);
        wait_evt(200, cyc, kind);
        chk(kind == 1, "R2 fused ignores swen=0", kind, 1);

        // R3: disabled over a long window with sleep too
        do_reset();
        fuse_en = 1'b0; ps_sel = 3'd0;
        cycles(20);
        pulse_sleep();
        wait_evt(600, cyc, kind);
        chk(kind == 0, "R3 off stays quiet", kind, 0);
        chk(to_n == 1'b1, "R9 flag unchanged when off", to_n, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule